// File: doc/BRIEF.md
# Streaming Weighted Confidence Accumulator

This tile takes a stream of signed confidence samples, each paired with an unsigned integer weight. It keeps a weighted mean of those samples in the inverse-hyperbolic-tangent domain. Each accepted sample has its magnitude limited just below one. It is then mapped through atanh, and the weight times the mapped value is added to a signed running sum. The weight itself is added to a running weight total. Both registers saturate instead of wrapping.

On request, the tile divides the running sum by the weight total. The divisor is held at a floor of one, so an empty or all-zero-weight history cannot divide by zero. The quotient is mapped back through tanh, rounded once to the output format, limited to the open interval (-1, +1) and presented for a single cycle. Addition is exact and commutative, so any reordering of the same samples gives a bit-identical result.

Confidences are signed Q1.15 (the code c stands for c/32768). Transformed values use 30 fraction bits. A clear input empties the accumulator. While a result is being computed, the tile withholds its ready so that the sample source waits.

Top module: `wconf_accum`

## Requirements
- R1: Each accepted sample with non-zero weight w adds w·atanh(a) to the running sum and w to the weight total; a publish yields tanh(sum / max(total, 1)) as Q1.15 within 0.006 of the ideal value.
- R2: Before the transform, a sample magnitude above 32255/32768 is limited to 32255/32768, so codes 32767 and -32768 produce exactly the same result as 32255 and -32255.
- R3: Any permutation of the same samples and weights publishes a bit-identical out_conf.
- R4: Negating every sample confidence publishes exactly the two's-complement negation of the result.
- R5: A sample with weight 0 is consumed but leaves both accumulator registers unchanged.
- R6: With a weight total of 0, a publish yields exactly code 0.
- R7: clear sets both registers to zero, and it wins over a sample accepted in the same cycle.
- R8: The 48-bit signed sum saturates at +(2^47-1) and -2^47, and the 32-bit weight total saturates at 2^32-1; neither wraps.
- R9: A publish while idle raises busy from the next cycle until out_valid pulses for exactly one cycle. The result covers the samples accepted before that publish's clock edge. A publish while busy is ignored and produces no extra result.
- R10: in_ready is low whenever busy is high; a sample offered during that time is held by the source and is accepted exactly once after the result.
- R11: out_conf never takes code -32768, so every published magnitude is at most 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted on this edge when in_valid is high |
| in_conf | input | 16 | Signed Q1.15 confidence |
| in_weight | input | 16 | Unsigned integer weight |
| clear | input | 1 | Empty both accumulator registers |
| publish | input | 1 | Request a result from the current state |
| busy | output | 1 | Result computation in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_conf | output | 16 | Signed Q1.15 published confidence |

## Verification
The main function is driven with a mixed-sign set in three orders. Matching codes across orders separate true summation from any order-dependent scheme, such as running averages. The same set is replayed with every sign flipped to expose asymmetric rounding or clamping. Out-of-range codes are compared against the limit codes to locate the input clamp. Single huge-weight samples drive the sum into both saturation rails, and a wrapping adder would flip the published sign. A sample and a publish in the same cycle, and samples held while busy, show whether the result snapshots the registers before or after the sample.

// File: rtl/ssacc_pkg.sv
// Package: shared phase type and elaboration-time knot generators for the
// piecewise-linear atanh / tanh approximations. Knots are computed, never listed.
package ssacc_pkg;

    typedef enum logic {PH_IDLE, PH_DIVIDE} phase_t;

    // atanh at x = idx / 2^seg_bits, scaled by 2^frac_bits (magnitude only)
    function automatic longint atanh_knot(input int idx, input int seg_bits, input int frac_bits);
        real x;
        real v;
        x = real'(idx) / real'(1 << seg_bits);
        v = 0.5 * $ln((1.0 + x) / (1.0 - x));
        return longint'(v * (2.0 ** frac_bits));
    endfunction

    // tanh at x = idx * 2^range_bits / 2^seg_bits, scaled by 2^frac_bits
    function automatic longint tanh_knot(input int idx, input int seg_bits,
                                         input int range_bits, input int frac_bits);
        real x;
        real e;
        x = real'(idx) * real'(1 << range_bits) / real'(1 << seg_bits);
        e = $exp(2.0 * x);
        return longint'(((e - 1.0) / (e + 1.0)) * (2.0 ** frac_bits));
    endfunction

endpackage

// File: rtl/conf_to_u.sv
// conf_to_u: limits a signed fixed-point confidence to +/-A_LIM and maps its
// magnitude through atanh by linear interpolation between 2^SEG_BITS knots.
// Output is sign plus unsigned magnitude with U_FRAC fraction bits.
// Assumes A_LIM stays below the last knot so the next knot always exists.
module conf_to_u #(
    parameter int CONF_W   = 16,
    parameter int SEG_BITS = 6,
    parameter int U_FRAC   = 30,
    parameter int A_LIM    = 32255
) (
    input  logic signed [CONF_W-1:0] conf,
    output logic                     neg,
    output logic [U_FRAC+1:0]        mag
);
    localparam int MAG_W  = U_FRAC + 2;
    localparam int FRAC_W = CONF_W - 1 - SEG_BITS;
    localparam int SEGS   = 1 << SEG_BITS;
    localparam int PROD_W = MAG_W + FRAC_W;

    logic [MAG_W-1:0] knot [SEGS];

    for (genvar g = 0; g < SEGS; g++) begin : g_knot
        localparam logic [MAG_W-1:0] KV = MAG_W'(ssacc_pkg::atanh_knot(g, SEG_BITS, U_FRAC));
        assign knot[g] = KV;
    end

    logic [CONF_W-1:0]   abs_c;
    logic [CONF_W-1:0]   lim_c;
    logic [SEG_BITS-1:0] idx;
    logic [FRAC_W-1:0]   frac;
    logic [MAG_W-1:0]    lo;
    logic [MAG_W-1:0]    hi;
    logic [PROD_W-1:0]   slope;

    // clamp, split into segment index and fraction, interpolate
    always_comb begin
        abs_c = conf[CONF_W-1] ? CONF_W'(-conf) : CONF_W'(conf);
        lim_c = (abs_c > CONF_W'(A_LIM)) ? CONF_W'(A_LIM) : abs_c;
        idx   = lim_c[CONF_W-2 -: SEG_BITS];
        frac  = lim_c[FRAC_W-1:0];
        lo    = knot[idx];
        hi    = (idx == SEG_BITS'(SEGS - 1)) ? lo : knot[idx + SEG_BITS'(1)];
        slope = PROD_W'(hi - lo) * PROD_W'(frac);
        mag   = lo + MAG_W'(slope >> FRAC_W);
        neg   = conf[CONF_W-1] && (lim_c != '0);
    end

endmodule

// File: rtl/u_to_conf.sv
// u_to_conf: maps an unsigned quotient magnitude (U_FRAC fraction bits) through
// tanh over [0, 2^RANGE_BITS) by linear interpolation, rounds once to the
// confidence format, limits the magnitude to 2^(CONF_W-1)-1 and applies the sign.
// Assumes quotients at or beyond the range end take the last knot.
module u_to_conf #(
    parameter int CONF_W     = 16,
    parameter int SEG_BITS   = 6,
    parameter int RANGE_BITS = 2,
    parameter int U_FRAC     = 30,
    parameter int Q_W        = 48
) (
    input  logic                     neg,
    input  logic [Q_W-1:0]           qmag,
    output logic signed [CONF_W-1:0] conf
);
    localparam int STEP_W  = U_FRAC + RANGE_BITS - SEG_BITS;
    localparam int SEGS    = 1 << SEG_BITS;
    localparam int KN_W    = U_FRAC + 1;
    localparam int PROD_W  = KN_W + STEP_W;
    localparam int RSH     = U_FRAC - (CONF_W - 1);
    localparam int OUT_MAX = (1 << (CONF_W - 1)) - 1;

    logic [KN_W-1:0] knot [SEGS+1];

    for (genvar g = 0; g <= SEGS; g++) begin : g_knot
        localparam logic [KN_W-1:0] KV = KN_W'(ssacc_pkg::tanh_knot(g, SEG_BITS, RANGE_BITS, U_FRAC));
        assign knot[g] = KV;
    end

    logic                over;
    logic [SEG_BITS-1:0] idx;
    logic [STEP_W-1:0]   frac;
    logic [KN_W-1:0]     lo;
    logic [KN_W-1:0]     hi;
    logic [PROD_W-1:0]   slope;
    logic [KN_W-1:0]     y;
    logic [KN_W:0]       rsum;
    logic [KN_W:0]       rq;
    logic [CONF_W-1:0]   lim;

    // interpolate, round at the output format, limit and sign
    always_comb begin
        over  = |qmag[Q_W-1:U_FRAC+RANGE_BITS];
        idx   = qmag[U_FRAC+RANGE_BITS-1 -: SEG_BITS];
        frac  = qmag[STEP_W-1:0];
        lo    = knot[idx];
        hi    = knot[{1'b0, idx} + (SEG_BITS+1)'(1)];
        slope = PROD_W'(hi - lo) * PROD_W'(frac);
        y     = over ? knot[SEGS] : lo + KN_W'(slope >> STEP_W);
        rsum  = {1'b0, y} + (KN_W+1)'(1 << (RSH - 1));
        rq    = rsum >> RSH;
        lim   = (rq > (KN_W+1)'(OUT_MAX)) ? CONF_W'(OUT_MAX) : rq[CONF_W-1:0];
        conf  = neg ? $signed(CONF_W'(-lim)) : $signed(lim);
    end

endmodule

// File: rtl/seq_divider.sv
// seq_divider: restoring unsigned divider, one quotient bit per clock.
// start loads operands; N_W steps later done pulses for one cycle with the
// truncated quotient held in quotient. Assumes divisor is non-zero and start
// is not raised while busy.
module seq_divider #(
    parameter int N_W = 48,
    parameter int D_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           busy,
    output logic           done,
    output logic [N_W-1:0] quotient
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [D_W:0]   rem_q;
    logic [N_W-1:0] quo_q;
    logic [D_W-1:0] dv_q;
    logic [CNT_W-1:0] cnt_q;
    logic           done_q;
    logic [D_W:0]   trial;
    logic           fits;

    // trial subtraction for the next quotient bit
    always_comb begin
        trial = {rem_q[D_W-1:0], quo_q[N_W-1]};
        fits  = trial >= {1'b0, dv_q};
    end

    // operand load and shift/subtract iteration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dv_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            rem_q  <= '0;
            quo_q  <= dividend;
            dv_q   <= divisor;
            cnt_q  <= CNT_W'(N_W);
            done_q <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q  <= fits ? (trial - {1'b0, dv_q}) : trial;
            quo_q  <= {quo_q[N_W-2:0], fits};
            cnt_q  <= cnt_q - CNT_W'(1);
            done_q <= (cnt_q == CNT_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign busy     = (cnt_q != '0);
    assign done     = done_q;
    assign quotient = quo_q;

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_q < {1'b0, dv_q}));   // R1
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                    // R9

endmodule

// File: rtl/wconf_accum.sv
// wconf_accum: streaming weighted confidence accumulator. Accepted samples add
// weight*atanh(conf) to a saturating signed sum and weight to a saturating total.
// publish snapshots both, divides sum by max(total, W_EPS) over U_W cycles, maps
// back through tanh and strobes the rounded result for one cycle. Samples are
// refused while a result is being computed. Assumes synchronous active-low reset.
module wconf_accum #(
    parameter int CONF_W   = 16,
    parameter int WGT_W    = 16,
    parameter int U_W      = 48,
    parameter int W_W      = 32,
    parameter int U_FRAC   = 30,
    parameter int SEG_BITS = 6,
    parameter int A_LIM    = 32255,
    parameter int W_EPS    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [CONF_W-1:0] in_conf,
    input  logic [WGT_W-1:0]         in_weight,
    input  logic                     clear,
    input  logic                     publish,
    output logic                     busy,
    output logic                     out_valid,
    output logic signed [CONF_W-1:0] out_conf
);
    import ssacc_pkg::*;

    localparam int MAG_W  = U_FRAC + 2;
    localparam int PROD_W = MAG_W + WGT_W;
    localparam int SUM_W  = ((U_W > PROD_W) ? U_W : PROD_W) + 2;
    localparam logic signed [SUM_W-1:0] U_POS =
        $signed({{(SUM_W-U_W+1){1'b0}}, {(U_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] U_NEG = -U_POS - SUM_W'(1);

    logic signed [U_W-1:0] acc_u;
    logic [W_W-1:0]        acc_w;
    phase_t                phase;
    logic                  sign_q;

    logic                  c2u_neg;
    logic [MAG_W-1:0]      c2u_mag;
    logic [PROD_W-1:0]     prod;
    logic signed [SUM_W-1:0] sum_ext;
    logic signed [U_W-1:0] u_next;
    logic [W_W:0]          w_sum;
    logic [W_W-1:0]        w_next;
    logic                  take;
    logic                  start;
    logic [U_W-1:0]        u_abs;
    logic [W_W-1:0]        den;
    logic                  div_busy;
    logic                  div_done;
    logic [U_W-1:0]        div_q;
    logic signed [CONF_W-1:0] conf_pub;

    conf_to_u #(
        .CONF_W(CONF_W), .SEG_BITS(SEG_BITS), .U_FRAC(U_FRAC), .A_LIM(A_LIM)
    ) u_c2u (
        .conf(in_conf), .neg(c2u_neg), .mag(c2u_mag)
    );

    // weighted contribution and saturating next values of both registers
    always_comb begin
        prod    = PROD_W'(c2u_mag) * PROD_W'(in_weight);
        sum_ext = c2u_neg ? (SUM_W'(acc_u) - $signed(SUM_W'(prod)))
                          : (SUM_W'(acc_u) + $signed(SUM_W'(prod)));
        if (sum_ext > U_POS)
            u_next = U_W'(U_POS);
        else if (sum_ext < U_NEG)
            u_next = U_W'(U_NEG);
        else
            u_next = U_W'(sum_ext);
        w_sum  = {1'b0, acc_w} + (W_W+1)'(in_weight);
        w_next = w_sum[W_W] ? '1 : w_sum[W_W-1:0];
    end

    // handshake, publish start and guarded divisor
    always_comb begin
        in_ready = (phase == PH_IDLE);
        busy     = (phase == PH_DIVIDE);
        take     = in_valid && in_ready && (in_weight != '0);
        start    = publish && (phase == PH_IDLE);
        u_abs    = acc_u[U_W-1] ? U_W'(-acc_u) : U_W'(acc_u);
        den      = (acc_w < W_W'(W_EPS)) ? W_W'(W_EPS) : acc_w;
    end

    // accumulator registers: clear beats a same-cycle sample
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_u <= '0;
            acc_w <= '0;
        end else if (take) begin
            acc_u <= u_next;
            acc_w <= w_next;
        end
    end

    seq_divider #(.N_W(U_W), .D_W(W_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(u_abs), .divisor(den),
        .busy(div_busy), .done(div_done), .quotient(div_q)
    );

    u_to_conf #(
        .CONF_W(CONF_W), .SEG_BITS(SEG_BITS), .RANGE_BITS(2),
        .U_FRAC(U_FRAC), .Q_W(U_W)
    ) u_u2c (
        .neg(sign_q), .qmag(div_q), .conf(conf_pub)
    );

    // publish sequencing and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            sign_q    <= 1'b0;
            out_valid <= 1'b0;
            out_conf  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (start) begin
                phase  <= PH_DIVIDE;
                sign_q <= acc_u[U_W-1];
            end else if ((phase == PH_DIVIDE) && div_done) begin
                phase     <= PH_IDLE;
                out_valid <= 1'b1;
                out_conf  <= conf_pub;
            end
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_u == '0 && acc_w == '0));                           // R7
    AST_ZERO_WT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && in_valid && in_weight == '0) |=> ($stable(acc_u) && $stable(acc_w)));  // R5
    AST_W_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (acc_w >= $past(acc_w)));                               // R8
    AST_U_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && take && !c2u_neg && !acc_u[U_W-1]) |=> !acc_u[U_W-1]);  // R8
    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                         // R9
    AST_BUSY_ENDS_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid);                                        // R9
    AST_DIV_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> busy);                                                // R10
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_conf != $signed({1'b1, {(CONF_W-1){1'b0}}})));  // R11

endmodule

// File: tb/tb_wconf_accum.sv
`timescale 1ns/1ps
module tb_wconf_accum;

    localparam real TOL   = 0.006;
    localparam int  LIMC  = 32255;
    localparam real U_SAT = 131072.0;   // 2^47 / 2^30

    localparam int M_TOL = 0, M_TOL_SAVE = 1, M_SAME = 2, M_NEG = 3, M_EXACT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [15:0] in_conf = '0;
    logic [15:0] in_weight = '0;
    logic clear = 1'b0;
    logic publish = 1'b0;
    logic busy;
    logic out_valid;
    logic signed [15:0] out_conf;

    always #2 clk = ~clk;

    wconf_accum dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_conf(in_conf), .in_weight(in_weight), .clear(clear), .publish(publish),
        .busy(busy), .out_valid(out_valid), .out_conf(out_conf)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    // scoreboard queues
    int    q_mode[$];
    real   q_val[$];
    string q_tag[$];

    real mU = 0.0;
    real mW = 0.0;
    int  saved = 0;
    bit  prev_ov = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic real atanh_r(input real x);
        return 0.5 * $ln((1.0 + x) / (1.0 - x));
    endfunction

    function automatic real tanh_r(input real x);
        real e;
        e = $exp(2.0 * x);
        return (e - 1.0) / (e + 1.0);
    endfunction

    function automatic real lim_conf(input int c);
        int m;
        m = (c < 0) ? -c : c;
        if (m > LIMC) m = LIMC;
        return (c < 0) ? -real'(m) / 32768.0 : real'(m) / 32768.0;
    endfunction

    function automatic real expect_now();
        real d;
        d = (mW < 1.0) ? 1.0 : mW;
        return tanh_r(mU / d);
    endfunction

    task automatic model_add(input int c, input int w);
        if (w != 0) begin
            mU = mU + real'(w) * atanh_r(lim_conf(c));
            if (mU > U_SAT) mU = U_SAT;
            if (mU < -U_SAT) mU = -U_SAT;
            mW = mW + real'(w);
        end
    endtask

    // driver: offer one sample, wait for acceptance
    task automatic send(input int c, input int w);
        @(negedge clk);
        in_valid  = 1'b1;
        in_conf   = 16'(c);
        in_weight = 16'(w);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        model_add(c, w);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        mU = 0.0;
        mW = 0.0;
    endtask

    task automatic push(input int mode, input real val, input string tag);
        q_mode.push_back(mode);
        q_val.push_back(val);
        q_tag.push_back(tag);
    endtask

    // driver: publish and push the expected item, then wait for completion
    task automatic pub(input int mode, input string tag);
        @(negedge clk);
        publish = 1'b1;
        push(mode, expect_now(), tag);
        @(negedge clk);
        publish = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pop and compare on every result strobe
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int    mode;
            real   val;
            string tag;
            int    got;
            got = int'(out_conf);
            check(!prev_ov, "R9 out_valid longer than one cycle", 1, 0);
            check(got != -32768, "R11 out_conf range", got, -32767);
            if (q_mode.size() == 0) begin
                check(1'b0, "R9 unexpected result", got, 0);
            end else begin
                mode = q_mode.pop_front();
                val  = q_val.pop_front();
                tag  = q_tag.pop_front();
                case (mode)
                    M_TOL, M_TOL_SAVE: begin
                        real diff;
                        diff = real'(got) / 32768.0 - val;
                        if (diff < 0.0) diff = -diff;
                        check(diff <= TOL, tag, got, longint'(val * 32768.0));
                        if (mode == M_TOL_SAVE) saved = got;
                    end
                    M_SAME:  check(got == saved, tag, got, saved);
                    M_NEG:   check(got == -saved, tag, got, -saved);
                    default: check(got == 0, tag, got, 0);
                endcase
            end
        end
        prev_ov = out_valid;
    end

    initial begin
        #800000;
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(busy == 1'b0, "R9 reset busy", busy, 0);
        check(in_ready == 1'b1, "R10 reset ready", in_ready, 1);
        check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);

        // R6: empty accumulator publishes exactly zero
        pub(M_EXACT, "R6 zero total");

        // R1: mixed set, order A
        send(16384, 3); send(-8192, 1); send(29491, 2); send(3277, 5);
        pub(M_TOL_SAVE, "R1 weighted mean");
        // R3: reversed order
        do_clear();
        send(3277, 5); send(29491, 2); send(-8192, 1); send(16384, 3);
        pub(M_SAME, "R3 reversed order");
        // R3: interleaved order
        do_clear();
        send(29491, 2); send(16384, 3); send(3277, 5); send(-8192, 1);
        pub(M_SAME, "R3 shuffled order");
        // R4: every sign flipped
        do_clear();
        send(-16384, 3); send(8192, 1); send(-29491, 2); send(-3277, 5);
        pub(M_NEG, "R4 negated set");

        // R5: zero-weight sample has no effect
        do_clear();
        send(-20000, 4); send(12000, 1);
        pub(M_TOL_SAVE, "R1 second set");
        send(22938, 0);
        pub(M_SAME, "R5 zero weight ignored");

        // R2: out-of-range codes equal the limit codes
        do_clear();
        send(32767, 4); send(-32768, 2);
        pub(M_TOL_SAVE, "R2 beyond limit");
        do_clear();
        send(LIMC, 4); send(-LIMC, 2);
        pub(M_SAME, "R2 at limit");

        // R7: clear wins over same-cycle sample
        do_clear();
        send(10000, 3);
        @(negedge clk);
        in_valid = 1'b1; in_conf = 16'sd20000; in_weight = 16'd7; clear = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; clear = 1'b0;
        mU = 0.0; mW = 0.0;
        pub(M_EXACT, "R7 clear priority");

        // R8: saturation at both rails
        do_clear();
        send(32767, 65535); send(32767, 65535);
        pub(M_TOL, "R8 positive saturation");
        do_clear();
        send(-32768, 65535); send(-32768, 65535);
        pub(M_TOL, "R8 negative saturation");

        // R9 / R10: busy window, back-pressure, ignored publish
        do_clear();
        send(9830, 2);
        @(negedge clk);
        publish = 1'b1;
        push(M_TOL, expect_now(), "R9 result before held sample");
        @(negedge clk);
        publish = 1'b0;
        in_valid = 1'b1; in_conf = 16'sd26214; in_weight = 16'd1;
        check(busy == 1'b1, "R9 busy after publish", busy, 1);
        begin
            int bad = 0;
            int n = 0;
            while (busy) begin
                if (in_ready) bad++;
                publish = (n == 3);
                n++;
                @(negedge clk);
            end
            publish = 1'b0;
            check(bad == 0, "R10 ready low while busy", bad, 0);
            check(n > 40, "R9 busy duration", n, 48);
        end
        @(negedge clk);
        in_valid = 1'b0;
        model_add(26214, 1);
        pub(M_TOL, "R10 held sample counted once");

        // R9: sample in the publish cycle is excluded from that result
        do_clear();
        send(13107, 1);
        @(negedge clk);
        in_valid = 1'b1; in_conf = 16'sd29491; in_weight = 16'd1; publish = 1'b1;
        push(M_TOL, expect_now(), "R9 snapshot excludes same-cycle sample");
        @(negedge clk);
        in_valid = 1'b0; publish = 1'b0;
        model_add(29491, 1);
        while (busy) @(negedge clk);
        pub(M_TOL, "R1 both samples included");

        repeat (5) @(negedge clk);
        check(q_mode.size() == 0, "R9 missing results", q_mode.size(), 0);
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule